// File: doc/BRIEF.md
# Multithreaded Context Register File

This block holds the architectural registers of several hardware threads that share one pipeline. Each thread owns a private bank of registers inside one flat storage array; an entry is found by joining the thread number (upper address bits) with the register index (lower address bits). Because every thread's state stays resident, moving the pipeline from one thread to another costs no cycle and copies nothing. Memory beyond this block is common to all threads and is not modelled here.

A thread selector picks, each cycle, which thread the pipeline issues from. In fine-grain mode it walks the threads round-robin and moves on every cycle. In coarse-grain mode it stays on one thread until a long-latency stall (a cache miss, an I/O wait) is signalled, then moves on. In both modes threads whose ready bit is low are passed over, and when no thread is ready the selector reports idle.

Two read ports and one write port each carry their own thread number, so a write-back can target a thread other than the one being issued. The interfaces are plain control signals with no back-pressure: reads are answered in the same cycle, a write with its enable high is always accepted, and the issue outputs carry a valid flag that the pipeline consumes or ignores; the stall input is the only hold mechanism.

Top module: `mtctx_regfile`

## Requirements
- R1: Reset clears every register of every thread to zero and sets the selection pointer to thread 0, so with all threads ready the first cycle issues thread 0.
- R2: A write with wr_en high stores wr_data only into entry {wr_tid, wr_idx}; the new value is readable from the next cycle, and the same index of every other thread keeps its value, whichever thread is being issued.
- R3: Each read port independently returns, in the same cycle, the content of entry {tid, idx} given on that port.
- R4: A read of the entry being written in the same cycle returns the value held before the write.
- R5: In fine-grain mode (sel_coarse = 0) with all threads ready, the issued thread advances by one every cycle in the order 0, 1, 2, 3, 0.
- R6: The selector issues only ready threads: it issues the first ready thread found searching upward (with wrap) from the pointer, and in fine-grain mode the pointer then moves to the thread after the one issued.
- R7: In coarse-grain mode (sel_coarse = 1) without long_stall, the thread issued stays the same on the next cycle as long as it remains ready.
- R8: In coarse-grain mode, long_stall high in a cycle that issues thread t makes the next cycle issue the first ready thread after t.
- R9: With no thread ready, idle is 1, issue_valid is 0 and the pointer is held.
- R10: With wr_en low no register changes, whatever wr_tid, wr_idx and wr_data carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_coarse | input | 1 | 0 = fine-grain rotation, 1 = coarse-grain switching |
| thread_ready | input | NUM_THREADS | Per-thread ready bits, bit t for thread t |
| long_stall | input | 1 | Long-latency stall of the issued thread |
| issue_valid | output | 1 | A thread is issued this cycle |
| issue_tid | output | TID_W | Issued thread (shows the pointer when idle) |
| idle | output | 1 | No thread ready |
| rda_tid | input | TID_W | Read port A thread |
| rda_idx | input | RIDX_W | Read port A register index |
| rda_data | output | DATA_W | Read port A data |
| rdb_tid | input | TID_W | Read port B thread |
| rdb_idx | input | RIDX_W | Read port B register index |
| rdb_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_tid | input | TID_W | Write thread |
| wr_idx | input | RIDX_W | Write register index |
| wr_data | input | DATA_W | Write data |

## Verification
Read data and the issue outputs are combinational: they are due in the same cycle as the read address, ready bits and mode they depend on, while a write and a pointer move take effect one clock edge later. The bench therefore applies every input at the falling edge, compares all outputs against its behavioural model a nanosecond later, and only then lets the rising edge advance the model's registers and pointer. This places each same-cycle result and each one-cycle-late effect in exactly the cycle the requirements give.

// File: rtl/mtctx_pkg.sv
package mtctx_pkg;

  typedef enum logic {
    SEL_FINE   = 1'b0,
    SEL_COARSE = 1'b1
  } sel_mode_e;

endpackage

// File: rtl/mtctx_bank.sv
module mtctx_bank #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  parameter int NRD    = 2,
  parameter int ADDR_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [NRD-1:0][ADDR_W-1:0]   rd_addr,
  output logic [NRD-1:0][DATA_W-1:0]   rd_data
);

  logic [DEPTH-1:0][DATA_W-1:0] mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = mem[rd_addr[p]];
  end

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data)); // R2

  AST_NOWR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem)); // R10

endmodule

// File: rtl/mtctx_sched.sv
module mtctx_sched
  import mtctx_pkg::*;
#(
  parameter int NT    = 4,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sel_mode_e        mode,
  input  logic [NT-1:0]    ready,
  input  logic             long_stall,
  output logic             issue_valid,
  output logic [TID_W-1:0] issue_tid,
  output logic             idle
);

  logic [TID_W-1:0] ptr;
  logic [TID_W-1:0] ptr_nxt;
  logic [TID_W-1:0] after_issue;

  always_comb begin
    issue_valid = 1'b0;
    issue_tid   = ptr;
    for (int k = NT - 1; k >= 0; k--) begin
      if (ready[TID_W'((int'(ptr) + k) % NT)]) begin
        issue_valid = 1'b1;
        issue_tid   = TID_W'((int'(ptr) + k) % NT);
      end
    end
    idle = !issue_valid;
  end

  assign after_issue = (int'(issue_tid) == NT - 1) ? '0 : issue_tid + 1'b1;

  always_comb begin
    ptr_nxt = ptr;
    if (issue_valid) begin
      if (mode == SEL_COARSE && !long_stall) ptr_nxt = issue_tid;
      else                                   ptr_nxt = after_issue;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end

  AST_ISSUE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ready[issue_tid]); // R6

  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (ready == '0 && !issue_valid)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (!idle || issue_tid == $past(issue_tid))); // R9

  AST_COARSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SEL_COARSE && issue_valid && !long_stall) |=>
      (mode != SEL_COARSE || !ready[$past(issue_tid)] || issue_tid == $past(issue_tid))); // R7

  AST_FINE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SEL_FINE && issue_valid && $countones(ready) > 1) |=>
      (ready != $past(ready) || mode != SEL_FINE || issue_tid != $past(issue_tid))); // R5

endmodule

// File: rtl/mtctx_regfile.sv
module mtctx_regfile
  import mtctx_pkg::*;
#(
  parameter  int NUM_THREADS = 4,
  parameter  int NUM_REGS    = 8,
  parameter  int DATA_W      = 32,
  localparam int TID_W       = $clog2(NUM_THREADS),
  localparam int RIDX_W      = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_coarse,
  input  logic [NUM_THREADS-1:0] thread_ready,
  input  logic                   long_stall,
  output logic                   issue_valid,
  output logic [TID_W-1:0]       issue_tid,
  output logic                   idle,
  input  logic [TID_W-1:0]       rda_tid,
  input  logic [RIDX_W-1:0]      rda_idx,
  output logic [DATA_W-1:0]      rda_data,
  input  logic [TID_W-1:0]       rdb_tid,
  input  logic [RIDX_W-1:0]      rdb_idx,
  output logic [DATA_W-1:0]      rdb_data,
  input  logic                   wr_en,
  input  logic [TID_W-1:0]       wr_tid,
  input  logic [RIDX_W-1:0]      wr_idx,
  input  logic [DATA_W-1:0]      wr_data
);

  localparam int ADDR_W = TID_W + RIDX_W;
  localparam int DEPTH  = NUM_THREADS * NUM_REGS;
  localparam int NRD    = 2;

  sel_mode_e                     mode;
  logic [NRD-1:0][ADDR_W-1:0]    rd_addr;
  logic [NRD-1:0][DATA_W-1:0]    rd_data;

  assign mode       = sel_coarse ? SEL_COARSE : SEL_FINE;
  assign rd_addr[0] = {rda_tid, rda_idx};
  assign rd_addr[1] = {rdb_tid, rdb_idx};
  assign rda_data   = rd_data[0];
  assign rdb_data   = rd_data[1];

  mtctx_bank #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .NRD    (NRD),
    .ADDR_W (ADDR_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr ({wr_tid, wr_idx}),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  mtctx_sched #(
    .NT    (NUM_THREADS),
    .TID_W (TID_W)
  ) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .ready       (thread_ready),
    .long_stall  (long_stall),
    .issue_valid (issue_valid),
    .issue_tid   (issue_tid),
    .idle        (idle)
  );

endmodule

// File: tb/tb_mtctx_regfile.sv
`timescale 1ns/1ps
module tb_mtctx_regfile;

  localparam int NT = 4;
  localparam int NR = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_coarse = 1'b0;
  logic [NT-1:0] thread_ready = '0;
  logic          long_stall = 1'b0;
  logic          issue_valid;
  logic [1:0]    issue_tid;
  logic          idle;
  logic [1:0]    rda_tid = '0, rdb_tid = '0, wr_tid = '0;
  logic [2:0]    rda_idx = '0, rdb_idx = '0, wr_idx = '0;
  logic [DW-1:0] rda_data, rdb_data;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;

  always #2 clk = ~clk;

  mtctx_regfile #(.NUM_THREADS(NT), .NUM_REGS(NR), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .sel_coarse(sel_coarse), .thread_ready(thread_ready),
    .long_stall(long_stall), .issue_valid(issue_valid), .issue_tid(issue_tid), .idle(idle),
    .rda_tid(rda_tid), .rda_idx(rda_idx), .rda_data(rda_data),
    .rdb_tid(rdb_tid), .rdb_idx(rdb_idx), .rdb_data(rdb_data),
    .wr_en(wr_en), .wr_tid(wr_tid), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;
  string       tag    = "R1";
  logic [DW-1:0] mregs [NT*NR];
  int          mptr;

  task automatic chk(string t, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic set_rd(int a, int b);
    rda_tid = 2'(a / NR); rda_idx = 3'(a % NR);
    rdb_tid = 2'(b / NR); rdb_idx = 3'(b % NR);
  endtask

  task automatic set_wr(bit en, int e, logic [DW-1:0] d);
    wr_en = en; wr_tid = 2'(e / NR); wr_idx = 3'(e % NR); wr_data = d;
  endtask

  // one cycle: inputs already applied at the falling edge
  task automatic tick();
    bit ev; int et; int wa, ra, rb;
    ev = 1'b0; et = mptr;
    for (int k = NT - 1; k >= 0; k--)
      if (thread_ready[(mptr + k) % NT]) begin ev = 1'b1; et = (mptr + k) % NT; end
    wa = int'(wr_tid) * NR + int'(wr_idx);
    ra = int'(rda_tid) * NR + int'(rda_idx);
    rb = int'(rdb_tid) * NR + int'(rdb_idx);
    #1;
    chk(tag, "issue_valid", issue_valid, ev);
    chk(tag, "idle", idle, !ev);
    if (ev) chk(tag, "issue_tid", issue_tid, et);
    else    chk(tag, "held pointer", issue_tid, mptr);
    chk((wr_en && wa == ra) ? "R4" : tag, "rda_data", rda_data, mregs[ra]);
    chk((wr_en && wa == rb) ? "R4" : tag, "rdb_data", rdb_data, mregs[rb]);
    @(posedge clk);
    if (wr_en) mregs[wa] = wr_data;
    if (ev) mptr = (sel_coarse && !long_stall) ? et : (et + 1) % NT;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NT*NR; i++) mregs[i] = '0;
    mptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: pointer starts at thread 0, all registers zero
    tag = "R1"; thread_ready = 4'hF; set_rd(0, 31); tick();
    thread_ready = 4'h0;
    for (int e = 0; e < 16; e++) begin set_rd(e, e + 16); tick(); end
    // R2: write every entry, read back the previous one
    tag = "R2";
    for (int e = 0; e < NT*NR; e++) begin
      set_wr(1'b1, e, $urandom); set_rd((e + 31) % 32, (e + 16) % 32); tick();
    end
    set_wr(1'b0, 0, '0);
    // R3: two independent read ports
    tag = "R3";
    for (int e = 0; e < 16; e++) begin set_rd(e, 31 - e); tick(); end
    // R4: same-cycle read of the written entry sees old value
    tag = "R2";
    for (int k = 0; k < 4; k++) begin
      set_wr(1'b1, (k * 9) % 32, $urandom); set_rd((k * 9) % 32, (k * 9 + 1) % 32); tick();
      set_wr(1'b0, 0, '0); tick();
    end
    // R10: disabled writes leave everything unchanged
    tag = "R10";
    for (int e = 0; e < 32; e++) begin
      set_wr(1'b0, e, $urandom); set_rd(e, (e + 5) % 32); tick();
    end
    // R5: fine rotation, with write-backs to non-issued threads (R2)
    tag = "R5"; thread_ready = 4'hF; sel_coarse = 1'b0;
    for (int k = 0; k < 10; k++) begin
      set_wr(1'b1, ((k + 2) % NT) * NR + (k % NR), $urandom);
      set_rd(((k + 2) % NT) * NR + ((k + 7) % NR), k); tick();
    end
    set_wr(1'b0, 0, '0);
    // R6: skipping threads that are not ready
    tag = "R6";
    thread_ready = 4'b1010; repeat (4) tick();
    thread_ready = 4'b0100; repeat (3) tick();
    thread_ready = 4'b1001; repeat (4) tick();
    thread_ready = 4'b0111; repeat (4) tick();
    // R9: nothing ready
    tag = "R9";
    thread_ready = 4'b0000; repeat (3) tick();
    sel_coarse = 1'b1; repeat (2) tick();
    sel_coarse = 1'b0; thread_ready = 4'b0010; repeat (2) tick();
    // R7: coarse hold
    tag = "R7"; sel_coarse = 1'b1; thread_ready = 4'hF; repeat (6) tick();
    thread_ready = 4'b1100; repeat (3) tick();
    // R8: coarse switch on long stall
    tag = "R8"; thread_ready = 4'hF;
    for (int k = 0; k < 12; k++) begin long_stall = (k % 3 == 0); tick(); end
    thread_ready = 4'b0101; long_stall = 1'b1; repeat (4) tick();
    long_stall = 1'b0; repeat (2) tick();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule